// File: doc/BRIEF.md
# USB Host Interrupt Status Register

This block is the event-status register of a USB host controller. Five sticky flags record controller events: a system fault outside the bus, a resume signalled by a downstream device, the start of a frame, completion of the done-list head write to shared memory, and a schedule overrun. Internal logic raises each flag with a single-cycle strobe. Software reads the flags through a small register port and clears them by writing ones. A two-bit field beside the flags counts schedule overruns and wraps.

The block also guards the done-list head write to shared memory. A write request from the list engine waits while the done-head flag is set, because software has not yet consumed the previous head. The block grants it in the first cycle the flag reads clear. A second grant is also held back until the granted write reports completion. One interrupt line leaves the block. It is the registered OR of the flags ANDed with a software-written enable mask.

Top module: `usbh_irq_status`

## Requirements
- R1: After reset, every flag, the overrun count, the enable mask, `irq` and `wb_grant` are 0.
- R2: Address 0 reads the status word with the overrun flag at bit 0, done-head flag at bit 1, frame-start flag at bit 2, resume flag at bit 3, fault flag at bit 4 and the overrun count at bits 9:8. Address 1 reads the enable mask in bits 4:0. All other bits read 0. `rd_data` shows the value selected by `reg_addr` one clock later.
- R3: A pulse on `ev_resume` sets the resume flag only when `sw_resume_active` is 0 in that cycle.
- R4: `ev_sys_err`, `ev_sof`, `ev_sched_ovr` and `wb_done` each set their own flag. A set flag stays set until software clears it.
- R5: Writing address 0 clears each flag whose data bit is 1. Flags whose data bit is 0 keep their value.
- R6: When a set strobe and a software clear hit the same flag in the same cycle, the flag ends up set.
- R7: Each `ev_sched_ovr` pulse adds 1 to the overrun count, which wraps from 3 to 0. Register writes never change the count.
- R8: A `wb_req` pulse causes a one-cycle `wb_grant` in the next cycle if the done-head flag is 0. Otherwise the request is held, and the grant comes one cycle after the flag reads 0.
- R9: After a grant, no further grant is issued until `wb_done` has been seen. `wb_grant` is never high in two consecutive cycles.
- R10: `irq` equals the OR of the status flags ANDed with the enable mask, delayed by one clock.

Top module ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ev_sys_err | input | 1 | Strobe: fault outside the bus |
| ev_resume | input | 1 | Strobe: downstream device signalled resume |
| sw_resume_active | input | 1 | Software is driving resume on the bus |
| ev_sof | input | 1 | Strobe: frame started, frame number stored |
| ev_sched_ovr | input | 1 | Strobe: schedule overrun |
| wb_req | input | 1 | Strobe: request to write the done-list head |
| wb_done | input | 1 | Strobe: done-list head write finished |
| wb_grant | output | 1 | One-cycle permission to start the head write |
| reg_wr | input | 1 | Register write enable |
| reg_addr | input | ADDR_W | Register address (0 status, 1 mask) |
| reg_wdata | input | DATA_W | Register write data |
| rd_data | output | DATA_W | Registered read data |
| irq | output | 1 | Registered interrupt request |

## Verification
A flag stuck at 0 or 1, or a clear that reaches the wrong bit, appears in the status word read two clocks after the stimulus. With the matching mask bit set, it also appears on `irq` one clock after the flag changes. A wrong interlock state shows on `wb_grant` within one cycle of the request or of the flag clear: either a missing pulse or a pulse while the done-head flag is still set. A wrong count appears as a mismatch after a known number of overrun pulses, and the wrap from 3 to 0 exposes a count field of the wrong width.

// File: rtl/usbh_irq_pkg.sv
package usbh_irq_pkg;
  localparam int NFLAG   = 5;
  // status bit positions (software decodes these)
  localparam int B_SO    = 0;
  localparam int B_WDH   = 1;
  localparam int B_SOF   = 2;
  localparam int B_RD    = 3;
  localparam int B_UE    = 4;
  localparam int CNT_LSB = 8;
  localparam int A_STAT  = 0;
  localparam int A_MASK  = 1;
endpackage

// File: rtl/usbh_irq_flagbank.sv
module usbh_irq_flagbank #(
  parameter int NF = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NF-1:0] set_i,
  input  logic [NF-1:0] clr_i,
  output logic [NF-1:0] flags_o
);
  for (genvar i = 0; i < NF; i++) begin : g_bit
    logic f_q;
    always_ff @(posedge clk) begin
      if (rst)           f_q <= 1'b0;
      else if (set_i[i]) f_q <= 1'b1;   // set beats clear
      else if (clr_i[i]) f_q <= 1'b0;
    end
    assign flags_o[i] = f_q;
  end
endmodule

// File: rtl/usbh_irq_ovrcnt.sv
module usbh_irq_ovrcnt #(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o
);
  always_ff @(posedge clk) begin
    if (rst)        cnt_o <= '0;
    else if (inc_i) cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/usbh_wb_gate.sv
module usbh_wb_gate (
  input  logic clk,
  input  logic rst,
  input  logic req_i,
  input  logic done_i,
  input  logic hold_i,   // done-head flag
  output logic grant_o
);
  logic pend_q, busy_q, want, go;

  assign want = pend_q | req_i;
  assign go   = want & ~hold_i & ~busy_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q  <= 1'b0;
      busy_q  <= 1'b0;
      grant_o <= 1'b0;
    end else begin
      grant_o <= go;
      pend_q  <= want & ~go;
      if (go)          busy_q <= 1'b1;
      else if (done_i) busy_q <= 1'b0;
    end
  end
endmodule

// File: rtl/usbh_irq_status.sv
module usbh_irq_status
  import usbh_irq_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 2,
  parameter int CNT_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ev_sys_err,
  input  logic              ev_resume,
  input  logic              sw_resume_active,
  input  logic              ev_sof,
  input  logic              ev_sched_ovr,
  input  logic              wb_req,
  input  logic              wb_done,
  output logic              wb_grant,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq
);
  localparam int NF = NFLAG;

  logic [NF-1:0]    flags_q, set_v, clr_v, mask_q;
  logic [CNT_W-1:0] cnt_q;
  logic             wr_stat, wr_mask;
  logic [DATA_W-1:0] stat_word, mask_word;

  assign wr_stat = reg_wr && (reg_addr == ADDR_W'(A_STAT));
  assign wr_mask = reg_wr && (reg_addr == ADDR_W'(A_MASK));

  always_comb begin
    set_v        = '0;
    set_v[B_UE]  = ev_sys_err;
    set_v[B_RD]  = ev_resume & ~sw_resume_active;
    set_v[B_SOF] = ev_sof;
    set_v[B_WDH] = wb_done;
    set_v[B_SO]  = ev_sched_ovr;
  end

  assign clr_v = wr_stat ? reg_wdata[NF-1:0] : '0;

  usbh_irq_flagbank #(.NF(NF)) u_flags (
    .clk(clk), .rst(rst), .set_i(set_v), .clr_i(clr_v), .flags_o(flags_q)
  );

  usbh_irq_ovrcnt #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .inc_i(ev_sched_ovr), .cnt_o(cnt_q)
  );

  usbh_wb_gate u_gate (
    .clk(clk), .rst(rst), .req_i(wb_req), .done_i(wb_done),
    .hold_i(flags_q[B_WDH]), .grant_o(wb_grant)
  );

  always_ff @(posedge clk) begin
    if (rst)          mask_q <= '0;
    else if (wr_mask) mask_q <= reg_wdata[NF-1:0];
  end

  always_comb begin
    stat_word                    = '0;
    stat_word[NF-1:0]            = flags_q;
    stat_word[CNT_LSB +: CNT_W]  = cnt_q;
    mask_word                    = '0;
    mask_word[NF-1:0]            = mask_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
      irq     <= 1'b0;
    end else begin
      irq <= |(flags_q & mask_q);
      if (reg_addr == ADDR_W'(A_STAT))      rd_data <= stat_word;
      else if (reg_addr == ADDR_W'(A_MASK)) rd_data <= mask_word;
      else                                  rd_data <= '0;
    end
  end
endmodule

// File: rtl/usbh_irq_status_chk.sv
module usbh_irq_status_chk
  import usbh_irq_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 2,
  parameter int CNT_W  = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              ev_sys_err,
  input logic              ev_resume,
  input logic              sw_resume_active,
  input logic              ev_sched_ovr,
  input logic              wb_grant,
  input logic              irq,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic [NFLAG-1:0]  flags_q,
  input logic [NFLAG-1:0]  mask_q,
  input logic [CNT_W-1:0]  cnt_q
);
  logic clr_ue;
  assign clr_ue = reg_wr && (reg_addr == ADDR_W'(A_STAT)) && reg_wdata[B_UE];

  p_resume_set_r3: assert property (@(posedge clk) disable iff (rst)
    (ev_resume && !sw_resume_active) |=> flags_q[B_RD]);

  p_resume_blocked_r3: assert property (@(posedge clk) disable iff (rst)
    (ev_resume && sw_resume_active && !flags_q[B_RD]) |=> !flags_q[B_RD]);

  p_ue_sticky_r4: assert property (@(posedge clk) disable iff (rst)
    (flags_q[B_UE] && !clr_ue) |=> flags_q[B_UE]);

  p_set_wins_r6: assert property (@(posedge clk) disable iff (rst)
    (ev_sys_err && clr_ue) |=> flags_q[B_UE]);

  p_cnt_step_r7: assert property (@(posedge clk) disable iff (rst)
    ev_sched_ovr |=> cnt_q == CNT_W'($past(cnt_q) + 1'b1));

  p_cnt_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !ev_sched_ovr |=> $stable(cnt_q));

  p_grant_gated_r8: assert property (@(posedge clk) disable iff (rst)
    wb_grant |-> !$past(flags_q[B_WDH]));

  p_grant_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    wb_grant |=> !wb_grant);

  p_irq_source_r10: assert property (@(posedge clk) disable iff (rst)
    irq |-> ($past(flags_q & mask_q) != '0));
endmodule

bind usbh_irq_status usbh_irq_status_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)
) u_chk (.*);

// File: tb/usbh_irq_status_tb.sv
`timescale 1ns/1ps
module usbh_irq_status_tb;
  localparam int DATA_W = 16;
  localparam int ADDR_W = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ev_sys_err = 0, ev_resume = 0, sw_resume_active = 0, ev_sof = 0;
  logic ev_sched_ovr = 0, wb_req = 0, wb_done = 0, reg_wr = 0;
  logic [ADDR_W-1:0] reg_addr = '0;
  logic [DATA_W-1:0] reg_wdata = '0;
  logic [DATA_W-1:0] rd_data;
  logic wb_grant, irq;

  int checks = 0, errors = 0, cnt_model = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  usbh_irq_status #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(2)) u_dut (
    .clk(clk), .rst(rst), .ev_sys_err(ev_sys_err), .ev_resume(ev_resume),
    .sw_resume_active(sw_resume_active), .ev_sof(ev_sof),
    .ev_sched_ovr(ev_sched_ovr), .wb_req(wb_req), .wb_done(wb_done),
    .wb_grant(wb_grant), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .rd_data(rd_data), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // v bits: 4 fault, 3 resume, 2 frame start, 1 head written, 0 overrun
  task automatic pulse(input logic [4:0] v);
    @(negedge clk);
    ev_sys_err = v[4]; ev_resume = v[3]; ev_sof = v[2];
    wb_done = v[1]; ev_sched_ovr = v[0];
    if (v[0]) cnt_model = (cnt_model + 1) % 4;
    @(negedge clk);
    {ev_sys_err, ev_resume, ev_sof, wb_done, ev_sched_ovr} = '0;
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    reg_wr = 1; reg_addr = ADDR_W'(a); reg_wdata = DATA_W'(d);
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = ADDR_W'(a);
    @(negedge clk);
    d = 32'(rd_data);
  endtask

  function automatic logic [31:0] stat(input int flags);
    return 32'(flags) | 32'(cnt_model << 8);
  endfunction

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 irq", 32'(irq), 0);
    chk("R1 grant", 32'(wb_grant), 0);
    rd(0, d); chk("R1 status", d, 0);
    rd(1, d); chk("R1 mask", d, 0);
  endtask

  task automatic t_events();
    logic [31:0] d;
    pulse(5'b10000); rd(0, d); chk("R4 fault flag bit4", d, stat('h10));
    pulse(5'b00100); rd(0, d); chk("R4 frame flag bit2", d, stat('h14));
    pulse(5'b00001); rd(0, d); chk("R4 overrun flag bit0 R2 count", d, stat('h15));
    pulse(5'b00010); rd(0, d); chk("R4 head flag bit1", d, stat('h17));
    repeat (3) @(negedge clk);
    rd(0, d); chk("R4 flags sticky", d, stat('h17));
    wr(0, 'h1f); rd(0, d); chk("R5 clear all", d, stat(0));
  endtask

  task automatic t_w1c();
    logic [31:0] d;
    pulse(5'b10100);
    wr(0, 'h04); rd(0, d); chk("R5 clear bit2 only", d, stat('h10));
    wr(0, 'h00); rd(0, d); chk("R5 zero write no effect", d, stat('h10));
    wr(0, 'h10); rd(0, d); chk("R5 clear bit4", d, stat(0));
  endtask

  task automatic t_resume();
    logic [31:0] d;
    sw_resume_active = 1;
    pulse(5'b01000); rd(0, d); chk("R3 resume suppressed", d, stat(0));
    sw_resume_active = 0;
    pulse(5'b01000); rd(0, d); chk("R3 resume flag bit3", d, stat('h08));
    wr(0, 'h08);
  endtask

  task automatic t_set_wins();
    logic [31:0] d;
    @(negedge clk);
    ev_sof = 1; reg_wr = 1; reg_addr = 0; reg_wdata = 'h04;
    @(negedge clk);
    ev_sof = 0; reg_wr = 0;
    rd(0, d); chk("R6 set beats clear", d, stat('h04));
    wr(0, 'h04);
  endtask

  task automatic t_count();
    logic [31:0] d;
    for (int i = 0; i < 5; i++) begin
      pulse(5'b00001);
      rd(0, d); chk("R7 overrun count", d, stat('h01));
    end
    wr(0, 'h0301); rd(0, d); chk("R7 write leaves count", d, stat(0));
    wr(1, 'h0300); rd(0, d); chk("R7 mask write leaves count", d, stat(0));
    wr(1, 0);
  endtask

  task automatic t_wb();
    logic [31:0] d;
    @(negedge clk); wb_req = 1;
    @(negedge clk); wb_req = 0;
    chk("R8 immediate grant", 32'(wb_grant), 1);
    @(negedge clk); chk("R9 grant one cycle", 32'(wb_grant), 0);
    pulse(5'b00010);
    rd(0, d); chk("R4 head flag set", d, stat('h02));
    @(negedge clk); wb_req = 1;
    @(negedge clk); wb_req = 0;
    chk("R8 held while flag set", 32'(wb_grant), 0);
    repeat (3) @(negedge clk);
    chk("R8 still held", 32'(wb_grant), 0);
    wr(0, 'h02);
    chk("R8 no grant in clear cycle", 32'(wb_grant), 0);
    @(negedge clk); chk("R8 grant after flag clears", 32'(wb_grant), 1);
    @(negedge clk); chk("R9 held grant one cycle", 32'(wb_grant), 0);
    pulse(5'b00010); wr(0, 'h02);
  endtask

  task automatic t_busy();
    @(negedge clk); wb_req = 1;
    @(negedge clk); wb_req = 0;
    chk("R8 grant", 32'(wb_grant), 1);
    wb_req = 1;
    @(negedge clk); wb_req = 0;
    chk("R9 no grant while in flight", 32'(wb_grant), 0);
    repeat (3) @(negedge clk);
    chk("R9 still waiting", 32'(wb_grant), 0);
    pulse(5'b00010);
    @(negedge clk); chk("R9 waits for flag after done", 32'(wb_grant), 0);
    wr(0, 'h02);
    @(negedge clk); chk("R9 grant after done and clear", 32'(wb_grant), 1);
    pulse(5'b00010); wr(0, 'h02);
  endtask

  task automatic t_irq();
    logic [31:0] d;
    wr(1, 'h04);
    rd(1, d); chk("R2 mask readback", d, 'h04);
    pulse(5'b00100);
    chk("R10 irq lags flag", 32'(irq), 0);
    @(negedge clk); chk("R10 irq raised", 32'(irq), 1);
    pulse(5'b10000);
    wr(0, 'h04);
    chk("R10 irq one cycle after clear", 32'(irq), 1);
    @(negedge clk); chk("R10 masked flag no irq", 32'(irq), 0);
    wr(1, 'h10);
    @(negedge clk); chk("R10 irq after unmask", 32'(irq), 1);
    wr(0, 'h1f); wr(1, 0);
    @(negedge clk); @(negedge clk);
    chk("R10 irq low", 32'(irq), 0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset();
    t_events();
    t_w1c();
    t_resume();
    t_set_wins();
    t_count();
    t_wb();
    t_busy();
    t_irq();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule